// File: doc/BRIEF.md
# Embedded Interval and Watchdog Timer Unit

This block holds three timers that advance on a shared time-base tick. The first is a programmable down-counter with optional automatic reload. The second is a fixed-interval timer that fires each time a selected bit of an internal tick counter toggles. The third is a watchdog that steps through arm, interrupt and reset stages whenever software fails to service it. A 32-bit control register configures all three. A 32-bit status register records their events, and software clears its bits by writing ones.

The outputs are three level interrupt requests and three one-clock reset strobes for the core, the chip and the system. Software can also force any of the three resets at once through a separate debug-reset write. The processor-side register access path lies outside this block. The unit sees only decoded write strobes with their data, and presents the current register values as outputs.

Period choices are powers of two. The fixed-interval timer uses 2^(FIT_BASE + PER_STEP*s) ticks and the watchdog uses 2^(WDT_BASE + PER_STEP*s) ticks, where s is the 2-bit select field. The defaults give 2^9 to 2^21 ticks for the fixed-interval timer and 2^17 to 2^29 ticks for the watchdog.

Top module: `embedded_timer_unit`

## Requirements
- R1: After a synchronous active-low reset, control, status and PIT count read 0, and every interrupt and reset strobe is low.
- R2: With s = TCR[25:24], TSR[26] sets one clock after every 2^(FIT_BASE+PER_STEP*s)-th tick since reset. fit_irq equals TSR[26] AND TCR[23].
- R3: A reload write of N (N at least 2) while TCR[26]=1 loads the count with N, and each tick lowers it by one. On the tick where the count is 1, TSR[27] sets. pit_irq equals TSR[27] AND TCR[26].
- R4: On expiry, the count returns to N and keeps running if TCR[22]=1. If TCR[22]=0, the count becomes 0 and stops.
- R5: A reload write of 0 or 1, or any reload write while TCR[26]=0, leaves the PIT stopped. While TCR[26]=0 the count holds its value, and a stopped PIT restarts only on a new reload write.
- R6: With w = TCR[31:30], a watchdog period ends every 2^(WDT_BASE+PER_STEP*w) ticks. When a period ends and TSR[31]=0, the only status change is that TSR[31] sets.
- R7: When a watchdog period ends with TSR[31]=1 and TSR[30]=0, TSR[30] sets. wdt_irq equals TSR[30] AND TCR[27].
- R8: When a watchdog period ends with TSR[31] and TSR[30] both set, TCR[29:28] is copied into TSR[29:28]. One clock later a single-cycle strobe follows that code: 1 core_rst, 2 chip_rst, 3 sys_rst, 0 none. Later periods are inert until TSR[31] or TSR[30] is cleared.
- R9: A debug-reset write with code 1, 2 or 3 pulses core_rst, chip_rst or sys_rst one clock later. Code 0 does nothing. In the same cycle, a debug request wins over a watchdog reset.
- R10: Writing 1 to a bit of the clear mask clears that status bit. An event that sets the same bit in the same cycle wins.
- R11: At most one reset strobe is high in any cycle.
- R12: A control write stores all 32 bits, and control reads back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_tick | input | 1 | Time-base tick enable, one clock per tick |
| tcr_we | input | 1 | Control register write strobe |
| tcr_wdata | input | 32 | Control register write data |
| tsr_w1c_we | input | 1 | Status clear strobe |
| tsr_w1c_mask | input | 32 | Status bits to clear (1 = clear) |
| pit_we | input | 1 | PIT reload write strobe |
| pit_wdata | input | PIT_W | PIT reload value |
| dbg_rst_we | input | 1 | Debug forced-reset write strobe |
| dbg_rst_code | input | 2 | Forced reset kind: 0 none, 1 core, 2 chip, 3 system |
| tcr_q | output | 32 | Current control register |
| tsr_q | output | 32 | Current status register |
| pit_count | output | PIT_W | Current PIT count |
| pit_irq | output | 1 | PIT interrupt request |
| fit_irq | output | 1 | Fixed-interval interrupt request |
| wdt_irq | output | 1 | Watchdog interrupt request |
| core_rst | output | 1 | Core reset strobe |
| chip_rst | output | 1 | Chip reset strobe |
| sys_rst | output | 1 | System reset strobe |

## Verification
Most internal faults reach tsr_q or pit_count within one clock. A wrong period tap shows as TSR[26] or TSR[31:30] setting one clock early or late against the tick count. A stuck watchdog latch, which records that the reset stage has fired, shows only at the next watchdog period: a second strobe appears, or an expected strobe goes missing after a service write. A PIT run flag left set after a stop shows as pit_count moving on the next tick. The bench therefore compares every output against a behavioural model on every clock, so such faults are reported in the cycle they first reach a port.

// File: rtl/embedded_timer_pkg.sv
// Package: shared types and field positions for the embedded timer unit.
// Assumes 32-bit control and status registers; field positions are fixed
// because software and the watchdog sequencing decode them.
package embedded_timer_pkg;

    typedef enum logic [1:0] {
        RST_NONE   = 2'd0,
        RST_CORE   = 2'd1,
        RST_CHIP   = 2'd2,
        RST_SYSTEM = 2'd3
    } rst_kind_e;

    // Control register fields
    localparam int CTL_WDT_PER_LO  = 30;  // [31:30] watchdog period select
    localparam int CTL_WDT_KIND_LO = 28;  // [29:28] watchdog reset kind
    localparam int CTL_WDT_IE      = 27;
    localparam int CTL_PIT_IE      = 26;
    localparam int CTL_FIT_PER_LO  = 24;  // [25:24] fixed interval select
    localparam int CTL_FIT_IE      = 23;
    localparam int CTL_PIT_AUTO    = 22;

    // Status register fields
    localparam int STS_WDT_ARM     = 31;
    localparam int STS_WDT_INT     = 30;
    localparam int STS_WDT_KIND_LO = 28;  // [29:28] last watchdog reset kind
    localparam int STS_PIT         = 27;
    localparam int STS_FIT         = 26;

endpackage

// File: rtl/etu_period_tap.sv
// Module: etu_period_tap
// Flags the tick on which bit K of the tick counter toggles, where
// K = BASE + STEP*sel. That bit toggles once every 2^K ticks, exactly when
// the low K bits of the counter are all ones as the tick arrives.
// Assumes BASE >= 1 and that the counter slice covers BASE + 3*STEP bits.
module etu_period_tap #(
    parameter int BASE = 9,
    parameter int STEP = 4,
    localparam int TAP_W = BASE + 3 * STEP
) (
    input  logic [TAP_W-1:0] cnt,
    input  logic             tick,
    input  logic [1:0]       sel,
    output logic             fire
);

    logic [3:0] hit;

    // One all-ones detector per selectable period
    for (genvar i = 0; i < 4; i++) begin : g_tap
        localparam int K = BASE + STEP * i;
        assign hit[i] = &cnt[K-1:0];
    end

    // The selected detector qualifies the tick
    assign fire = tick & hit[sel];

endmodule

// File: rtl/etu_pit.sv
// Module: etu_pit
// Programmable down-counter. It loads on a reload write, counts on ticks
// while enabled, and flags expiry on the tick where the count is 1. After
// expiry it reloads when auto is set and otherwise stops at 0.
// Assumes int_en and auto_en come straight from the control register.
module etu_pit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         int_en,
    input  logic         auto_en,
    output logic [W-1:0] count,
    output logic         expire
);

    logic [W-1:0] reload_q;
    logic [W-1:0] count_q;
    logic         run_q;

    // Expiry: a running, enabled counter reaching its last tick
    assign expire = tick && run_q && int_en && !load_en && (count_q == W'(1));

    // Reload, count-down and stop rules
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            count_q  <= '0;
            run_q    <= 1'b0;
        end else if (load_en) begin
            reload_q <= load_val;
            count_q  <= load_val;
            run_q    <= (load_val > W'(1)) && int_en;
        end else if (!int_en) begin
            run_q    <= 1'b0;
        end else if (tick && run_q) begin
            if (count_q == W'(1)) begin
                if (auto_en) begin
                    count_q <= reload_q;
                end else begin
                    count_q <= '0;
                    run_q   <= 1'b0;
                end
            end else begin
                count_q <= count_q - W'(1);
            end
        end
    end

    assign count = count_q;

endmodule

// File: rtl/etu_watchdog.sv
// Module: etu_watchdog
// Three-stage watchdog sequencer. At the end of each period it arms, then
// flags an interrupt, then requests a reset. The reset request is issued
// once and is not repeated until software clears either status stage bit.
// Assumes armed and flagged are the live status bits.
module etu_watchdog (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic armed,
    input  logic flagged,
    output logic set_arm,
    output logic set_flag,
    output logic take_reset
);

    logic done_q;

    // Stage decode against the current status
    assign set_arm    = fire && !armed;
    assign set_flag   = fire && armed && !flagged;
    assign take_reset = fire && armed && flagged && !done_q;

    // Remember that the reset stage fired until the watchdog is serviced
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (take_reset) begin
            done_q <= 1'b1;
        end else if (!(armed && flagged)) begin
            done_q <= 1'b0;
        end
    end

endmodule

// File: rtl/embedded_timer_unit.sv
// Module: embedded_timer_unit (top)
// Holds the tick counter, the control and status registers and the reset
// strobe stage. It ties together the PIT, two period taps (fixed interval
// and watchdog) and the watchdog sequencer. Status bits are write-one-to-clear,
// and a set from an event in the same cycle wins. Assumes FIT_BASE <= WDT_BASE.
module embedded_timer_unit
    import embedded_timer_pkg::*;
#(
    parameter int FIT_BASE = 9,
    parameter int WDT_BASE = 17,
    parameter int PER_STEP = 4,
    parameter int PIT_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_tick,
    input  logic             tcr_we,
    input  logic [31:0]      tcr_wdata,
    input  logic             tsr_w1c_we,
    input  logic [31:0]      tsr_w1c_mask,
    input  logic             pit_we,
    input  logic [PIT_W-1:0] pit_wdata,
    input  logic             dbg_rst_we,
    input  logic [1:0]       dbg_rst_code,
    output logic [31:0]      tcr_q,
    output logic [31:0]      tsr_q,
    output logic [PIT_W-1:0] pit_count,
    output logic             pit_irq,
    output logic             fit_irq,
    output logic             wdt_irq,
    output logic             core_rst,
    output logic             chip_rst,
    output logic             sys_rst
);

    localparam int FIT_CW = FIT_BASE + 3 * PER_STEP;
    localparam int WDT_CW = WDT_BASE + 3 * PER_STEP;
    localparam int CNT_W  = (WDT_CW > FIT_CW) ? WDT_CW : FIT_CW;

    logic [CNT_W-1:0] tb_cnt_q;
    logic [31:0]      tcr_r;
    logic [31:0]      tsr_r;
    logic [31:0]      tsr_n;
    logic             fit_fire;
    logic             wdt_fire;
    logic             pit_expire;
    logic             wd_set_arm;
    logic             wd_set_flag;
    logic             wd_take_reset;
    rst_kind_e        rst_kind;
    logic             core_q;
    logic             chip_q;
    logic             sys_q;

    // Free-running tick counter shared by both period taps
    always_ff @(posedge clk) begin
        if (!rst_n)       tb_cnt_q <= '0;
        else if (tb_tick) tb_cnt_q <= tb_cnt_q + CNT_W'(1);
    end

    // Control register, written whole
    always_ff @(posedge clk) begin
        if (!rst_n)      tcr_r <= '0;
        else if (tcr_we) tcr_r <= tcr_wdata;
    end

    etu_period_tap #(.BASE(FIT_BASE), .STEP(PER_STEP)) u_fit_tap (
        .cnt  (tb_cnt_q[FIT_CW-1:0]),
        .tick (tb_tick),
        .sel  (tcr_r[CTL_FIT_PER_LO +: 2]),
        .fire (fit_fire)
    );

    etu_period_tap #(.BASE(WDT_BASE), .STEP(PER_STEP)) u_wdt_tap (
        .cnt  (tb_cnt_q[WDT_CW-1:0]),
        .tick (tb_tick),
        .sel  (tcr_r[CTL_WDT_PER_LO +: 2]),
        .fire (wdt_fire)
    );

    etu_pit #(.W(PIT_W)) u_pit (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tb_tick),
        .load_en  (pit_we),
        .load_val (pit_wdata),
        .int_en   (tcr_r[CTL_PIT_IE]),
        .auto_en  (tcr_r[CTL_PIT_AUTO]),
        .count    (pit_count),
        .expire   (pit_expire)
    );

    etu_watchdog u_wdt (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (wdt_fire),
        .armed      (tsr_r[STS_WDT_ARM]),
        .flagged    (tsr_r[STS_WDT_INT]),
        .set_arm    (wd_set_arm),
        .set_flag   (wd_set_flag),
        .take_reset (wd_take_reset)
    );

    // Status next value: clear by mask first, then apply event sets
    always_comb begin
        tsr_n = tsr_r & ~(tsr_w1c_we ? tsr_w1c_mask : 32'h0);
        if (wd_set_arm)    tsr_n[STS_WDT_ARM] = 1'b1;
        if (wd_set_flag)   tsr_n[STS_WDT_INT] = 1'b1;
        if (wd_take_reset) tsr_n[STS_WDT_KIND_LO +: 2] = tcr_r[CTL_WDT_KIND_LO +: 2];
        if (pit_expire)    tsr_n[STS_PIT] = 1'b1;
        if (fit_fire)      tsr_n[STS_FIT] = 1'b1;
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) tsr_r <= '0;
        else        tsr_r <= tsr_n;
    end

    // Reset kind this cycle: debug request first, then watchdog
    always_comb begin
        if (dbg_rst_we && (dbg_rst_code != RST_NONE))
            rst_kind = rst_kind_e'(dbg_rst_code);
        else if (wd_take_reset)
            rst_kind = rst_kind_e'(tcr_r[CTL_WDT_KIND_LO +: 2]);
        else
            rst_kind = RST_NONE;
    end

    // Registered single-cycle reset strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= 1'b0;
            chip_q <= 1'b0;
            sys_q  <= 1'b0;
        end else begin
            core_q <= (rst_kind == RST_CORE);
            chip_q <= (rst_kind == RST_CHIP);
            sys_q  <= (rst_kind == RST_SYSTEM);
        end
    end

    assign tcr_q    = tcr_r;
    assign tsr_q    = tsr_r;
    assign pit_irq  = tsr_r[STS_PIT]     & tcr_r[CTL_PIT_IE];
    assign fit_irq  = tsr_r[STS_FIT]     & tcr_r[CTL_FIT_IE];
    assign wdt_irq  = tsr_r[STS_WDT_INT] & tcr_r[CTL_WDT_IE];
    assign core_rst = core_q;
    assign chip_rst = chip_q;
    assign sys_rst  = sys_q;

endmodule

// File: rtl/embedded_timer_unit_chk.sv
// Module: embedded_timer_unit_chk
// Port-level temporal checks for embedded_timer_unit, bound to every
// instance. Assumes the synchronous active-low reset is low from time zero.
module embedded_timer_unit_chk #(
    parameter int PIT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tb_tick,
    input logic             pit_we,
    input logic             tsr_w1c_we,
    input logic [31:0]      tsr_w1c_mask,
    input logic             dbg_rst_we,
    input logic [1:0]       dbg_rst_code,
    input logic [31:0]      tcr_q,
    input logic [31:0]      tsr_q,
    input logic [PIT_W-1:0] pit_count,
    input logic             core_rst,
    input logic             chip_rst,
    input logic             sys_rst
);

    assert_rst_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_rst, chip_rst, sys_rst}));

    assert_dbg_core_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rst_we && dbg_rst_code == 2'd1) |=> core_rst);

    assert_stage_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tsr_q[30]) |-> $past(tsr_q[31]));

    assert_arm_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tsr_q[31]) && !$past(tsr_w1c_we)) |-> $stable(tsr_q[30:28]));

    assert_pit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tcr_q[26] && !pit_we) |=> $stable(pit_count));

    assert_rst_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst || chip_rst || sys_rst) |->
            ($past(dbg_rst_we) || $past(tsr_q[31] && tsr_q[30])));

    assert_fit_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tsr_q[26]) |-> $past(tb_tick));

    assert_w1c_pit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tsr_w1c_we && tsr_w1c_mask[27] && !tb_tick) |=> !tsr_q[27]);

endmodule

bind embedded_timer_unit embedded_timer_unit_chk #(.PIT_W(PIT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tb_tick      (tb_tick),
    .pit_we       (pit_we),
    .tsr_w1c_we   (tsr_w1c_we),
    .tsr_w1c_mask (tsr_w1c_mask),
    .dbg_rst_we   (dbg_rst_we),
    .dbg_rst_code (dbg_rst_code),
    .tcr_q        (tcr_q),
    .tsr_q        (tsr_q),
    .pit_count    (pit_count),
    .core_rst     (core_rst),
    .chip_rst     (chip_rst),
    .sys_rst      (sys_rst)
);

// File: tb/embedded_timer_unit_tb_top.sv
// Bench: a behavioural reference model, updated on each rising edge, is
// compared with every output on each falling edge. Inputs change only
// just after a falling edge.
module embedded_timer_unit_tb_top;

    localparam int FB = 2;
    localparam int WB = 5;
    localparam int ST = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_tick = 1'b0;
    logic        tcr_we = 1'b0;
    logic [31:0] tcr_wdata = '0;
    logic        tsr_w1c_we = 1'b0;
    logic [31:0] tsr_w1c_mask = '0;
    logic        pit_we = 1'b0;
    logic [31:0] pit_wdata = '0;
    logic        dbg_rst_we = 1'b0;
    logic [1:0]  dbg_rst_code = '0;
    logic [31:0] tcr_q, tsr_q, pit_count;
    logic        pit_irq, fit_irq, wdt_irq, core_rst, chip_rst, sys_rst;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit slow     = 0;

    always #10 clk = ~clk;

    embedded_timer_unit #(.FIT_BASE(FB), .WDT_BASE(WB), .PER_STEP(ST), .PIT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick),
        .tcr_we(tcr_we), .tcr_wdata(tcr_wdata),
        .tsr_w1c_we(tsr_w1c_we), .tsr_w1c_mask(tsr_w1c_mask),
        .pit_we(pit_we), .pit_wdata(pit_wdata),
        .dbg_rst_we(dbg_rst_we), .dbg_rst_code(dbg_rst_code),
        .tcr_q(tcr_q), .tsr_q(tsr_q), .pit_count(pit_count),
        .pit_irq(pit_irq), .fit_irq(fit_irq), .wdt_irq(wdt_irq),
        .core_rst(core_rst), .chip_rst(chip_rst), .sys_rst(sys_rst)
    );

    // Reference model state
    longint      m_cnt;
    logic [31:0] m_tcr, m_tsr, m_pc, m_rel;
    bit          m_run, m_done, m_core, m_chip, m_sys;

    always @(posedge clk) begin : model
        int          kf, kw;
        longint      pf, pw;
        bit          fitf, wdtf, expp, s_arm, s_flag, take;
        logic [31:0] nt;
        logic [1:0]  kind;
        if (!rst_n) begin
            m_cnt = 0; m_tcr = 0; m_tsr = 0; m_pc = 0; m_rel = 0;
            m_run = 0; m_done = 0; m_core = 0; m_chip = 0; m_sys = 0;
        end else begin
            kf = FB + ST * int'(m_tcr[25:24]);
            kw = WB + ST * int'(m_tcr[31:30]);
            pf = longint'(1) << kf;
            pw = longint'(1) << kw;
            fitf = tb_tick && ((m_cnt % pf) == pf - 1);
            wdtf = tb_tick && ((m_cnt % pw) == pw - 1);
            expp = 0;
            if (pit_we) begin
                m_rel = pit_wdata; m_pc = pit_wdata;
                m_run = (pit_wdata > 1) && m_tcr[26];
            end else if (!m_tcr[26]) begin
                m_run = 0;
            end else if (tb_tick && m_run) begin
                if (m_pc == 1) begin
                    expp = 1;
                    if (m_tcr[22]) m_pc = m_rel;
                    else begin m_pc = 0; m_run = 0; end
                end else m_pc = m_pc - 1;
            end
            s_arm  = wdtf && !m_tsr[31];
            s_flag = wdtf && m_tsr[31] && !m_tsr[30];
            take   = wdtf && m_tsr[31] && m_tsr[30] && !m_done;
            if (take) m_done = 1;
            else if (!(m_tsr[31] && m_tsr[30])) m_done = 0;
            nt = m_tsr;
            if (tsr_w1c_we) nt = nt & ~tsr_w1c_mask;
            if (s_arm)  nt[31] = 1;
            if (s_flag) nt[30] = 1;
            if (take)   nt[29:28] = m_tcr[29:28];
            if (expp)   nt[27] = 1;
            if (fitf)   nt[26] = 1;
            if (dbg_rst_we && dbg_rst_code != 0) kind = dbg_rst_code;
            else if (take) kind = m_tcr[29:28];
            else kind = 0;
            m_core = (kind == 1); m_chip = (kind == 2); m_sys = (kind == 3);
            m_tsr = nt;
            if (tcr_we) m_tcr = tcr_wdata;
            if (tb_tick) m_cnt = m_cnt + 1;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%08h expected=%08h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        chk("R12", "tcr_q", tcr_q, m_tcr);
        chk("R2 R6 R7 R8 R10", "tsr_q", tsr_q, m_tsr);
        chk("R3 R4 R5", "pit_count", pit_count, m_pc);
        chk("R3", "pit_irq", 32'(pit_irq), 32'(m_tsr[27] & m_tcr[26]));
        chk("R2", "fit_irq", 32'(fit_irq), 32'(m_tsr[26] & m_tcr[23]));
        chk("R7", "wdt_irq", 32'(wdt_irq), 32'(m_tsr[30] & m_tcr[27]));
        chk("R8 R9 R11", "core_rst", 32'(core_rst), 32'(m_core));
        chk("R8 R9 R11", "chip_rst", 32'(chip_rst), 32'(m_chip));
        chk("R8 R9 R11", "sys_rst", 32'(sys_rst), 32'(m_sys));
    endtask

    // Advance n clocks; compare, then drop one-shot strobes and set the tick
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            tcr_we = 0; tsr_w1c_we = 0; pit_we = 0; dbg_rst_we = 0;
            tb_tick = rst_n && (slow ? ((cyc % 3) != 0) : 1'b1);
            cyc++;
        end
    endtask

    task automatic wr_tcr(input logic [31:0] v);
        tcr_we = 1; tcr_wdata = v; step(1);
    endtask
    task automatic clr_tsr(input logic [31:0] m);
        tsr_w1c_we = 1; tsr_w1c_mask = m; step(1);
    endtask
    task automatic wr_pit(input logic [31:0] v);
        pit_we = 1; pit_wdata = v; step(1);
    endtask
    task automatic dbg_rst(input logic [1:0] c);
        dbg_rst_we = 1; dbg_rst_code = c; step(2);
    endtask

    initial begin
        step(3);
        // R1: reset state
        chk("R1", "reset outputs",
            {tcr_q | tsr_q | pit_count} | 32'({pit_irq, fit_irq, wdt_irq, core_rst, chip_rst, sys_rst}), 32'h0);
        rst_n = 1;
        step(1);
        // R2: fixed interval, periods 4 and 8, with steady and gapped ticks
        wr_tcr(32'h0080_0000); step(20);
        clr_tsr(32'h0400_0000); step(10);
        wr_tcr(32'h0180_0000); step(30);
        slow = 1; step(30); slow = 0;
        clr_tsr(32'h0400_0000);
        // R3 R4: PIT with auto reload, then single shot
        wr_tcr(32'h0440_0000); wr_pit(5); step(20);
        clr_tsr(32'h0800_0000);
        wr_tcr(32'h0400_0000); wr_pit(3); step(10);
        // R5: no start on 0, 1 or disabled; hold when disabled mid-count
        wr_pit(1); step(5); wr_pit(0); step(3);
        wr_tcr(32'h0); wr_pit(6); step(5);
        wr_tcr(32'h0400_0000); wr_pit(9); step(4);
        wr_tcr(32'h0); step(5);
        // R6 R7 R8: watchdog stages for each reset code, period 32 ticks
        for (int c = 1; c <= 4; c++) begin
            wr_tcr(((c % 4) << 28) | 32'h0800_0000);
            clr_tsr(32'hF000_0000);
            step(140);
        end
        // R8: period 64 with chip reset, partly with gapped ticks
        wr_tcr(32'h6800_0000); clr_tsr(32'hF000_0000);
        slow = 1; step(150); slow = 0; step(150);
        // R9: forced resets, including code 0
        wr_tcr(32'h0);
        dbg_rst(2'd1); dbg_rst(2'd2); dbg_rst(2'd3); dbg_rst(2'd0);
        // R10: clear everything while events keep running
        wr_tcr(32'h0480_0000); wr_pit(2); step(8);
        clr_tsr(32'hFFFF_FFFF); step(8);
        // R12: arbitrary control pattern reads back whole
        wr_tcr(32'hDEAD_BEEF); step(40);
        wr_tcr(32'h0); step(4);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule